// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block runs whole SMBus transactions as bus host, one request at a time. A request gives an operation code, a 7-bit target address, a command byte, a length for the block forms, a PEC enable and a single bit for the quick form. The sequencer walks the frame that belongs to the operation and drives a bit-level I2C engine one primitive at a time. The primitives are start, repeated start, stop, write byte and read byte. The engine reports each completion with the target's acknowledge or the byte it received.

Write payload comes from a small buffer outside the block. The sequencer presents an index on `wbuf_idx` and takes the byte back on `wbuf_data` in the same cycle. Each data byte received is streamed out on `rd_valid`/`rd_data`. The length byte and the PEC byte are not streamed. At the end a single-cycle `done` pulse carries an error code and the number of data bytes received.

Top module: `smb_txn_seq`

## Requirements
- R1: The first address byte is {addr[6:0], dir}. dir is 1 only for receive byte (op 2). The quick form (op 0) puts `req_qbit` in the dir position and issues only start, that byte and stop. Op codes: 0 quick, 1 send byte, 2 receive byte, 3 write byte, 4 read byte, 5 write word, 6 read word, 7 process call, 8 block write, 9 block read, 10 I2C block write, 11 I2C block read.
- R2: Ops 4, 6, 7, 9 and 11 first write the address byte with dir 0 and then the command byte. Any write payload follows. They then issue a repeated start and write {addr, 1} before reading. Ops 1 to 11 other than 2 carry the command byte except op 1, whose single byte is payload.
- R3: On reads, every received byte is acknowledged (`cmd_nack`=0) except the last byte of the transaction, which is NACKed (`cmd_nack`=1) just before stop.
- R4: Word forms move the low byte first. Buffer index 0 is sent first, and the first byte received is streamed first.
- R5: Block write (op 8) sends `req_len` as a count byte after the command, then `req_len` payload bytes. I2C block write (op 10) sends the payload with no count byte. A length of 0 is allowed for both.
- R6: Block read (op 9) takes its data length from the first byte the target returns. I2C block read (op 11) reads `req_len` bytes and expects no count byte.
- R7: A request with an unknown op (12 to 15), a length above MAX_BLK for ops 8 to 11, or length 0 for op 11 finishes with error 6. It issues no primitive.
- R8: With PEC enabled on a write-only operation, a CRC-8 byte is written right before stop. The CRC uses polynomial 0x07, starts at 0x00, and covers every address byte, the command, the count and the payload. The quick form never carries PEC.
- R9: With PEC enabled on a read operation, one more byte is read and NACKed before stop. The CRC covers both address bytes, the command, any write payload, the count and the read data. If the extra byte differs from the CRC, the error is 5, and the data is still streamed.
- R10: A NACK aborts the transaction with stop. The error is 1 on either address byte, 2 on the command byte, and 3 on a count, payload or PEC byte.
- R11: A block-read count of 0 or above MAX_BLK gives error 4. The host reads and NACKs one more byte, then issues stop.
- R12: At most one primitive is outstanding. `cmd_valid` is a one-cycle pulse and the next one comes only after `eng_done`. `done` is a one-cycle pulse with `busy` low. Primitive codes: 0 start, 1 repeated start, 2 stop, 3 write, 4 read. Error 0 means success.
- R13: Each streamed data byte appears on `rd_data` with `rd_valid` in the cycle after the engine's completion that delivered it. `rx_count` at `done` equals the number of bytes streamed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken while not busy |
| req_op | input | 4 | Operation code |
| req_addr | input | 7 | Target address |
| req_cmd | input | 8 | Command byte |
| req_len | input | LEN_W | Length for block forms |
| req_pec | input | 1 | Append or check PEC |
| req_qbit | input | 1 | Direction bit of the quick form |
| wbuf_idx | output | LEN_W | Payload buffer index |
| wbuf_data | input | 8 | Payload byte at `wbuf_idx` |
| cmd_valid | output | 1 | Primitive issue pulse |
| cmd_kind | output | 3 | Primitive code |
| cmd_byte | output | 8 | Byte to write |
| cmd_nack | output | 1 | Acknowledge bit to send after a read |
| eng_done | input | 1 | Primitive completed |
| eng_nack | input | 1 | Target NACKed the written byte |
| eng_rdata | input | 8 | Byte read by the engine |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction finished pulse |
| err | output | 3 | Error code, valid with `done` |
| rd_valid | output | 1 | Received data byte strobe |
| rd_data | output | 8 | Received data byte |
| rx_count | output | LEN_W | Data bytes received in this transaction |

## Verification
The bench keeps the defaults, MAX_BLK = 32 and LEN_W = 6, so the full 32-byte block length is reachable alongside the one-past-limit count of 33. It sweeps every operation code with PEC on and off, using lengths 0, 1, 2 and 32 for the block forms. A model engine records each primitive and compares it with a frame and CRC that the bench computes from the requirements. Injected NACKs at each phase, bad counts, corrupted PEC bytes and rejected requests cover the abort paths.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;

    typedef enum logic [3:0] {
        OP_QUICK, OP_SEND, OP_RECV, OP_WR_BYTE, OP_RD_BYTE, OP_WR_WORD,
        OP_RD_WORD, OP_PCALL, OP_BLK_WR, OP_BLK_RD, OP_I2C_WR, OP_I2C_RD
    } smb_op_e;

    typedef enum logic [2:0] {
        PK_START, PK_RSTART, PK_STOP, PK_WRITE, PK_READ
    } prim_e;

    typedef enum logic [2:0] {
        E_OK, E_ADDR_NACK, E_CMD_NACK, E_DATA_NACK, E_BAD_COUNT, E_PEC, E_BAD_REQ
    } err_e;

    typedef enum logic [3:0] {
        PH_IDLE, PH_START, PH_ADDR1, PH_CMD, PH_WCNT, PH_WDATA, PH_WPEC,
        PH_RSTART, PH_ADDR2, PH_RCNT, PH_RDATA, PH_RPEC, PH_DRAIN, PH_STOP
    } phase_e;

    // Frame shape of one operation
    typedef struct packed {
        logic quick;     // address byte only
        logic first_rd;  // read direction in the first address byte
        logic has_cmd;   // command byte follows the address
        logic wr_cnt;    // count byte precedes the payload
        logic rd_rs;     // repeated start then read phase
        logic rd_cnt;    // read length comes from the target
    } op_info_t;

endpackage

// File: rtl/smb_crc8.sv
module smb_crc8 #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic [7:0] crc_in,
    input  logic [7:0] din,
    output logic [7:0] crc_out
);
    logic [7:0] acc;

    // MSB-first bitwise division, unrolled over the eight bits
    always_comb begin
        acc = crc_in ^ din;
        for (int i = 0; i < 8; i++) begin
            acc = acc[7] ? ((acc << 1) ^ POLY) : (acc << 1);
        end
        crc_out = acc;
    end
endmodule

// File: rtl/smb_op_decode.sv
module smb_op_decode
    import smb_seq_pkg::*;
#(
    parameter int MAX_BLK = 32,
    parameter int LEN_W   = 6
) (
    input  logic [3:0]       op,
    input  logic [LEN_W-1:0] len,
    output op_info_t         info,
    output logic [LEN_W-1:0] wlen,
    output logic [LEN_W-1:0] rlen,
    output logic             bad
);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_BLK);

    logic known, len_wr, len_rd;

    always_comb begin
        info   = '0;
        wlen   = '0;
        rlen   = '0;
        known  = 1'b1;
        len_wr = 1'b0;
        len_rd = 1'b0;
        case (op)
            OP_QUICK:   info.quick = 1'b1;
            OP_SEND:    wlen = LEN_W'(1);
            OP_RECV:    begin info.first_rd = 1'b1; rlen = LEN_W'(1); end
            OP_WR_BYTE: begin info.has_cmd = 1'b1; wlen = LEN_W'(1); end
            OP_RD_BYTE: begin info.has_cmd = 1'b1; info.rd_rs = 1'b1; rlen = LEN_W'(1); end
            OP_WR_WORD: begin info.has_cmd = 1'b1; wlen = LEN_W'(2); end
            OP_RD_WORD: begin info.has_cmd = 1'b1; info.rd_rs = 1'b1; rlen = LEN_W'(2); end
            OP_PCALL: begin
                info.has_cmd = 1'b1; info.rd_rs = 1'b1;
                wlen = LEN_W'(2); rlen = LEN_W'(2);
            end
            OP_BLK_WR:  begin info.has_cmd = 1'b1; info.wr_cnt = 1'b1; len_wr = 1'b1; wlen = len; end
            OP_BLK_RD:  begin info.has_cmd = 1'b1; info.rd_rs = 1'b1; info.rd_cnt = 1'b1; end
            OP_I2C_WR:  begin info.has_cmd = 1'b1; len_wr = 1'b1; wlen = len; end
            OP_I2C_RD:  begin info.has_cmd = 1'b1; info.rd_rs = 1'b1; len_rd = 1'b1; rlen = len; end
            default:    known = 1'b0;
        endcase
        // Block operations (ops 8 to 11) must stay within MAX_BLK; a host-sized read needs at least one byte
        bad = !known || ((len_wr || len_rd || info.rd_cnt) && (len > MAX_L))
                     || (len_rd && (len == '0));
    end
endmodule

// File: rtl/smb_txn_seq.sv
module smb_txn_seq
    import smb_seq_pkg::*;
#(
    parameter int         MAX_BLK  = 32,
    parameter int         LEN_W    = $clog2(MAX_BLK + 1),
    parameter logic [7:0] PEC_POLY = 8'h07
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [3:0]       req_op,
    input  logic [6:0]       req_addr,
    input  logic [7:0]       req_cmd,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_pec,
    input  logic             req_qbit,
    output logic [LEN_W-1:0] wbuf_idx,
    input  logic [7:0]       wbuf_data,
    output logic             cmd_valid,
    output logic [2:0]       cmd_kind,
    output logic [7:0]       cmd_byte,
    output logic             cmd_nack,
    input  logic             eng_done,
    input  logic             eng_nack,
    input  logic [7:0]       eng_rdata,
    output logic             busy,
    output logic             done,
    output logic [2:0]       err,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic [LEN_W-1:0] rx_count
);
    localparam logic [7:0] MAX_B8 = 8'(MAX_BLK);

    typedef struct packed {
        phase_e           ph;
        logic             wt;      // primitive issued, awaiting completion
        logic [3:0]       op;
        logic [6:0]       addr;
        logic [7:0]       cmd;
        logic [LEN_W-1:0] len;
        logic             pec;
        logic             qbit;
        logic [LEN_W-1:0] idx;
        logic [LEN_W-1:0] rlen;
        logic [7:0]       crc;
        err_e             err;
        logic             done;
        logic             rdv;
        logic [7:0]       rdd;
        logic [LEN_W-1:0] rxc;
    } st_t;

    st_t st_q, st_d;

    op_info_t         info;
    logic [LEN_W-1:0] dec_wlen, dec_rlen, dec_len;
    logic [3:0]       dec_op;
    logic             dec_bad;
    prim_e            cur_kind;
    logic [7:0]       cur_byte, crc_byte, crc_nx;
    logic             cur_nack, last_w, last_r;
    phase_e           after_wr;

    assign dec_op  = (st_q.ph == PH_IDLE) ? req_op  : st_q.op;
    assign dec_len = (st_q.ph == PH_IDLE) ? req_len : st_q.len;

    smb_op_decode #(.MAX_BLK(MAX_BLK), .LEN_W(LEN_W)) dec_i (
        .op(dec_op), .len(dec_len), .info(info),
        .wlen(dec_wlen), .rlen(dec_rlen), .bad(dec_bad)
    );

    assign crc_byte = (cur_kind == PK_READ) ? eng_rdata : cur_byte;

    smb_crc8 #(.POLY(PEC_POLY)) crc_i (
        .crc_in(st_q.crc), .din(crc_byte), .crc_out(crc_nx)
    );

    assign last_w   = (st_q.idx == dec_wlen - 1'b1);
    assign last_r   = (st_q.idx == st_q.rlen - 1'b1);
    assign after_wr = info.rd_rs ? PH_RSTART : (st_q.pec ? PH_WPEC : PH_STOP);

    // Primitive for the current phase
    always_comb begin
        cur_kind = PK_WRITE;
        cur_byte = '0;
        cur_nack = 1'b0;
        case (st_q.ph)
            PH_START:  cur_kind = PK_START;
            PH_RSTART: cur_kind = PK_RSTART;
            PH_STOP:   cur_kind = PK_STOP;
            PH_ADDR1:  cur_byte = {st_q.addr, info.quick ? st_q.qbit : info.first_rd};
            PH_CMD:    cur_byte = st_q.cmd;
            PH_WCNT:   cur_byte = 8'(st_q.len);
            PH_WDATA:  cur_byte = wbuf_data;
            PH_WPEC:   cur_byte = st_q.crc;
            PH_ADDR2:  cur_byte = {st_q.addr, 1'b1};
            PH_RCNT:   cur_kind = PK_READ;
            PH_RDATA:  begin cur_kind = PK_READ; cur_nack = last_r && !st_q.pec; end
            PH_RPEC, PH_DRAIN: begin cur_kind = PK_READ; cur_nack = 1'b1; end
            default:   cur_kind = PK_WRITE;
        endcase
    end

    // Next-state
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.rdv  = 1'b0;
        if (st_q.ph == PH_IDLE) begin
            if (req_valid) begin
                st_d.op   = req_op;
                st_d.addr = req_addr;
                st_d.cmd  = req_cmd;
                st_d.len  = req_len;
                st_d.pec  = req_pec;
                st_d.qbit = req_qbit;
                st_d.idx  = '0;
                st_d.rlen = '0;
                st_d.rxc  = '0;
                st_d.crc  = '0;
                st_d.wt   = 1'b0;
                if (dec_bad) begin
                    st_d.err  = E_BAD_REQ;
                    st_d.done = 1'b1;
                end else begin
                    st_d.err = E_OK;
                    st_d.ph  = PH_START;
                end
            end
        end else if (!st_q.wt) begin
            st_d.wt = 1'b1;
        end else if (eng_done) begin
            st_d.wt = 1'b0;
            if (cur_kind == PK_WRITE || cur_kind == PK_READ) st_d.crc = crc_nx;
            case (st_q.ph)
                PH_START: st_d.ph = PH_ADDR1;
                PH_ADDR1: begin
                    if (eng_nack) begin
                        st_d.err = E_ADDR_NACK; st_d.ph = PH_STOP;
                    end else if (info.quick) begin
                        st_d.ph = PH_STOP;
                    end else if (info.first_rd) begin
                        st_d.rlen = dec_rlen; st_d.ph = PH_RDATA;
                    end else begin
                        st_d.ph = info.has_cmd ? PH_CMD : PH_WDATA;
                    end
                end
                PH_CMD: begin
                    if (eng_nack) begin
                        st_d.err = E_CMD_NACK; st_d.ph = PH_STOP;
                    end else if (info.wr_cnt) begin
                        st_d.ph = PH_WCNT;
                    end else begin
                        st_d.ph = (dec_wlen != '0) ? PH_WDATA : after_wr;
                    end
                end
                PH_WCNT: begin
                    if (eng_nack) begin
                        st_d.err = E_DATA_NACK; st_d.ph = PH_STOP;
                    end else begin
                        st_d.ph = (dec_wlen != '0) ? PH_WDATA : after_wr;
                    end
                end
                PH_WDATA: begin
                    if (eng_nack) begin
                        st_d.err = E_DATA_NACK; st_d.ph = PH_STOP;
                    end else if (last_w) begin
                        st_d.idx = '0; st_d.ph = after_wr;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
                PH_WPEC: begin
                    if (eng_nack) st_d.err = E_DATA_NACK;
                    st_d.ph = PH_STOP;
                end
                PH_RSTART: st_d.ph = PH_ADDR2;
                PH_ADDR2: begin
                    if (eng_nack) begin
                        st_d.err = E_ADDR_NACK; st_d.ph = PH_STOP;
                    end else if (info.rd_cnt) begin
                        st_d.ph = PH_RCNT;
                    end else begin
                        st_d.rlen = dec_rlen; st_d.ph = PH_RDATA;
                    end
                end
                PH_RCNT: begin
                    if (eng_rdata == 8'd0 || eng_rdata > MAX_B8) begin
                        st_d.err = E_BAD_COUNT; st_d.ph = PH_DRAIN;
                    end else begin
                        st_d.rlen = LEN_W'(eng_rdata); st_d.ph = PH_RDATA;
                    end
                end
                PH_RDATA: begin
                    st_d.rdv = 1'b1;
                    st_d.rdd = eng_rdata;
                    st_d.rxc = st_q.rxc + 1'b1;
                    st_d.idx = st_q.idx + 1'b1;
                    if (last_r) st_d.ph = st_q.pec ? PH_RPEC : PH_STOP;
                end
                PH_RPEC: begin
                    if (eng_rdata != st_q.crc) st_d.err = E_PEC;
                    st_d.ph = PH_STOP;
                end
                PH_DRAIN: st_d.ph = PH_STOP;
                PH_STOP: begin
                    st_d.done = 1'b1;
                    st_d.ph   = PH_IDLE;
                end
                default: st_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_valid = (st_q.ph != PH_IDLE) && !st_q.wt;
    assign cmd_kind  = cur_kind;
    assign cmd_byte  = cur_byte;
    assign cmd_nack  = cur_nack;
    assign wbuf_idx  = st_q.idx;
    assign busy      = (st_q.ph != PH_IDLE);
    assign done      = st_q.done;
    assign err       = st_q.err;
    assign rd_valid  = st_q.rdv;
    assign rd_data   = st_q.rdd;
    assign rx_count  = st_q.rxc;
endmodule

// File: rtl/smb_txn_seq_chk.sv
module smb_txn_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       eng_done,
    input logic       busy,
    input logic       done,
    input logic       rd_valid,
    input logic [7:0] rd_data,
    input logic [7:0] eng_rdata
);
    // R12: a primitive is issued for one cycle, then the sequencer waits
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R12: nothing reaches the engine between transactions
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid);

    // R12: done arrives with busy low
    a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R12: a bus transaction ends only on an engine completion (the stop)
    a_r12_done_after_engine: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(busy)) |-> $past(eng_done));

    // R13: streamed bytes follow the engine completion by one cycle
    a_r13_rd_follows_engine: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(eng_done) && rd_data == $past(eng_rdata)));
endmodule

bind smb_txn_seq smb_txn_seq_chk chk_i (.*);

// File: tb/smb_txn_seq_tb_top.sv
module smb_txn_seq_tb_top;
    localparam int LEN_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [3:0]       req_op = '0;
    logic [6:0]       req_addr = '0;
    logic [7:0]       req_cmd = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             req_pec = 1'b0;
    logic             req_qbit = 1'b0;
    logic [LEN_W-1:0] wbuf_idx;
    logic [7:0]       wbuf_data;
    logic             cmd_valid, cmd_nack;
    logic [2:0]       cmd_kind;
    logic [7:0]       cmd_byte;
    logic             eng_done = 1'b0, eng_nack = 1'b0;
    logic [7:0]       eng_rdata = '0;
    logic             busy, done, rd_valid;
    logic [2:0]       err;
    logic [7:0]       rd_data;
    logic [LEN_W-1:0] rx_count;

    always #5 clk = ~clk;

    smb_txn_seq dut_i (.*);

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    // expected frame
    int ek[0:127], eb[0:127], en[0:127], etag[0:127];
    int ne, nexd, exp_err;
    logic [7:0] exd[0:63], rsrc[0:63], bcrc;
    int nr;
    // observed
    int lk[0:127], lb[0:127], ln[0:127];
    int nl, ng;
    logic [7:0] gd[0:63];
    // engine model
    int nack_at = -1, wcnt = 0, rptr = 0, lat = 0;
    bit pend = 1'b0;

    function automatic logic [7:0] wpat(int i);
        return 8'(i * 37 + 90);
    endfunction
    function automatic logic [7:0] rpat(int i);
        return 8'(i * 29 + 8'hC3);
    endfunction
    function automatic logic [7:0] crc8(logic [7:0] c, logic [7:0] d);
        logic [7:0] x = c ^ d;
        for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
        return x;
    endfunction
    function automatic int enc(int k, int b, int n);
        return (k << 16) | ((k == 3 ? b : 0) << 8) | (k == 4 ? n : 0);
    endfunction

    assign wbuf_data = wpat(int'(wbuf_idx));

    always @(negedge clk) begin
        eng_done <= 1'b0;
        if (cmd_valid) begin
            if (nl < 128) begin
                lk[nl] = int'(cmd_kind); lb[nl] = int'(cmd_byte); ln[nl] = int'(cmd_nack);
            end
            nl++;
            eng_nack <= 1'b0;
            if (cmd_kind == 3'd3) begin eng_nack <= (wcnt == nack_at); wcnt++; end
            if (cmd_kind == 3'd4) begin eng_rdata <= rsrc[rptr]; rptr = (rptr + 1) % 64; end
            lat = 2; pend = 1'b1;
        end else if (pend) begin
            if (lat == 0) begin eng_done <= 1'b1; pend = 1'b0; end
            else lat--;
        end
        if (rd_valid && ng < 64) begin gd[ng] = rd_data; ng++; end
    end

    task automatic check(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic push(int k, int b, int n, int tag);
        ek[ne] = k; eb[ne] = b; en[ne] = n; etag[ne] = tag; ne++;
    endtask
    task automatic pushw(logic [7:0] b, int tag);
        push(3, int'(b), 0, tag);
        bcrc = crc8(bcrc, b);
    endtask

    // Expected frame from the requirements (R1 to R9)
    task automatic build(int op, logic [6:0] a, logic [7:0] c, int len, bit pec, bit q);
        int wn = 0, rn = 0;
        bit hc, rdrs, rdany;
        ne = 0; nr = 0; nexd = 0; exp_err = 0; bcrc = 8'h00;
        hc   = (op >= 3);
        rdrs = (op == 4 || op == 6 || op == 7 || op == 9 || op == 11);
        rdany = rdrs || op == 2;
        case (op)
            1, 3: wn = 1;
            5, 7: wn = 2;
            8, 10: wn = len;
            default: wn = 0;
        endcase
        case (op)
            2, 4: rn = 1;
            6, 7: rn = 2;
            9, 11: rn = len;
            default: rn = 0;
        endcase
        push(0, 0, 0, 0);
        if (op == 0) begin
            pushw({a, q}, 1);
            push(2, 0, 0, 0);
            return;
        end
        pushw({a, op == 2}, 1);
        if (hc) pushw(c, 2);
        if (op == 8) pushw(8'(len), 3);
        for (int i = 0; i < wn; i++) pushw(wpat(i), 3);
        if (rdrs) begin
            push(1, 0, 0, 0);
            pushw({a, 1'b1}, 1);
        end
        if (rdany) begin
            if (op == 9) begin
                rsrc[nr] = 8'(len); nr++;
                push(4, 0, 0, 0); bcrc = crc8(bcrc, 8'(len));
            end
            for (int i = 0; i < rn; i++) begin
                rsrc[nr] = rpat(i); nr++;
                exd[nexd] = rpat(i); nexd++;
                push(4, 0, (i == rn - 1 && !pec) ? 1 : 0, 0);
                bcrc = crc8(bcrc, rpat(i));
            end
            if (pec) begin
                rsrc[nr] = bcrc; nr++;
                push(4, 0, 1, 0);
            end
        end else if (pec) begin
            pushw(bcrc, 3);
        end
        push(2, 0, 0, 0);
    endtask

    task automatic run(string rq, int op, logic [6:0] a, logic [7:0] c, int len, bit pec, bit q,
                       int nk, int badcnt, bit pecbad);
        int bad_i, wi, pos;
        build(op, a, c, len, pec, q);
        if (op > 11 || ((op >= 8) && len > 32) || (op == 11 && len == 0)) begin
            ne = 0; nexd = 0; exp_err = 6;
        end
        if (nk >= 0) begin
            wi = 0; pos = -1;
            for (int i = 0; i < ne; i++) if (ek[i] == 3) begin
                if (wi == nk && pos < 0) pos = i;
                wi++;
            end
            exp_err = etag[pos]; ne = pos + 1; nexd = 0;
            push(2, 0, 0, 0);
        end
        if (badcnt >= 0) begin
            rsrc[0] = 8'(badcnt);
            pos = -1;
            for (int i = 0; i < ne; i++) if (ek[i] == 4 && pos < 0) pos = i;
            ne = pos + 1; nexd = 0; exp_err = 4;
            push(4, 0, 1, 0);
            push(2, 0, 0, 0);
        end
        if (pecbad) begin
            rsrc[nr - 1] = rsrc[nr - 1] ^ 8'h01;
            exp_err = 5;
        end
        nack_at = nk;
        @(negedge clk);
        nl = 0; ng = 0; wcnt = 0; rptr = 0;
        req_op = 4'(op); req_addr = a; req_cmd = c; req_len = LEN_W'(len);
        req_pec = pec; req_qbit = q; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        bad_i = -1;
        for (int i = 0; i < ne && i < nl; i++)
            if (bad_i < 0 && enc(lk[i], lb[i], ln[i]) != enc(ek[i], eb[i], en[i])) bad_i = i;
        if (nl != ne) check(1'b0, rq, "primitive count", nl, ne);
        else if (bad_i >= 0)
            check(1'b0, rq, $sformatf("primitive %0d", bad_i),
                  enc(lk[bad_i], lb[bad_i], ln[bad_i]), enc(ek[bad_i], eb[bad_i], en[bad_i]));
        else check(1'b1, rq, "frame", 0, 0);
        check(int'(err) == exp_err, rq, "error code", int'(err), exp_err);
        check(int'(rx_count) == nexd, "R13", "rx_count", int'(rx_count), nexd);
        bad_i = -1;
        for (int i = 0; i < nexd && i < ng; i++) if (bad_i < 0 && gd[i] != exd[i]) bad_i = i;
        if (ng != nexd) check(1'b0, "R13", "streamed byte count", ng, nexd);
        else if (bad_i >= 0) check(1'b0, "R13", "streamed byte", int'(gd[bad_i]), int'(exd[bad_i]));
        else check(1'b1, "R13", "stream", 0, 0);
        check(busy == 1'b0, "R12", "busy at done", int'(busy), 0);
        @(negedge clk);
        check(done == 1'b0, "R12", "done pulse width", int'(done), 0);
    endtask

    function automatic string op_req(int op, bit pec);
        if (pec && op != 0) return (op == 2 || op == 4 || op == 6 || op == 7 || op == 9 || op == 11) ? "R9" : "R8";
        case (op)
            0, 1, 3: return "R1";
            2: return "R3";
            4, 7: return "R2";
            5, 6: return "R4";
            8, 10: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        int lens[4] = '{0, 1, 2, 32};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(!busy && !done && !cmd_valid && !rd_valid, "R12", "reset outputs",
              {busy, done, cmd_valid, rd_valid}, 0);
        // Sweep of every operation, PEC off and on
        for (int op = 0; op < 12; op++) begin
            for (int p = 0; p < 2; p++) begin
                for (int li = 0; li < 4; li++) begin
                    if (op < 8 && li != 1) continue;
                    if ((op == 9 || op == 11) && lens[li] == 0) continue;
                    run(op_req(op, p[0]), op, 7'(8'h20 + op), 8'(8'h40 + li), (op < 8) ? 5 : lens[li],
                        p[0], p[0], -1, -1, 1'b0);
                end
            end
        end
        // R7: rejected requests
        run("R7", 8, 7'h33, 8'h01, 33, 1'b0, 1'b0, -1, -1, 1'b0);
        run("R7", 11, 7'h33, 8'h01, 0, 1'b0, 1'b0, -1, -1, 1'b0);
        run("R7", 13, 7'h33, 8'h01, 1, 1'b0, 1'b0, -1, -1, 1'b0);
        run("R7", 9, 7'h33, 8'h01, 40, 1'b1, 1'b0, -1, -1, 1'b0);
        // R10: NACK in each phase
        run("R10", 1, 7'h11, 8'h00, 1, 1'b0, 1'b0, 0, -1, 1'b0);
        run("R10", 6, 7'h12, 8'h07, 1, 1'b0, 1'b0, 1, -1, 1'b0);
        run("R10", 8, 7'h13, 8'h08, 4, 1'b0, 1'b0, 2, -1, 1'b0);
        run("R10", 8, 7'h13, 8'h08, 4, 1'b0, 1'b0, 4, -1, 1'b0);
        run("R10", 7, 7'h14, 8'h09, 1, 1'b1, 1'b0, 4, -1, 1'b0);
        run("R10", 3, 7'h15, 8'h0A, 1, 1'b1, 1'b0, 3, -1, 1'b0);
        run("R10", 0, 7'h16, 8'h00, 1, 1'b0, 1'b1, 0, -1, 1'b0);
        // R11: bad block-read counts
        run("R11", 9, 7'h17, 8'h0B, 3, 1'b0, 1'b0, -1, 0, 1'b0);
        run("R11", 9, 7'h17, 8'h0B, 3, 1'b1, 1'b0, -1, 33, 1'b0);
        // R9: corrupted PEC from the target
        run("R9", 6, 7'h18, 8'h0C, 1, 1'b1, 1'b0, -1, -1, 1'b1);
        run("R9", 9, 7'h19, 8'h0D, 32, 1'b1, 1'b0, -1, -1, 1'b1);
        run("R9", 2, 7'h1A, 8'h00, 1, 1'b1, 1'b0, -1, -1, 1'b1);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule